// File: doc/BRIEF.md
# Blitter Control Register Bank and Launch Logic

This block holds the control state of a 2D block-transfer engine. Software writes it one byte at a time through a memory-mapped window. The state covers the source and destination addresses, two pitches, a mode byte, a raster-operation code, a mode-extension byte and a start/status byte. The block hands the latched fields to the pixel datapath and decides when a transfer begins. The datapath and the video memory lie outside the block.

A transfer is launched in one of two ways: a write to the start/status byte with its go bit set, or, on the newer chip generation, a write to the top destination-address byte while the auto-start bit is latched. The mode decides what a launch does:

- In normal modes a launch raises a one-cycle start pulse.
- In host-source mode it starts no engine. Instead it arms a transfer that the CPU feeds. It raises a host-active flag, pulses a clear strobe for the datapath's host byte, bit-buffer, pixel and scanline counters, and snapshots both addresses into working copies.

A busy flag stays up from launch until the datapath reports completion.

Top module: `blt_regbank`

## Requirements
- R1: After reset every register reads 0x00, and busy, host-active, the start pulse and the clear strobe are all low.
- R2: The following byte offsets write and read back the stored value:
  - destination pitch: 0x00 low, 0x01 high
  - source pitch: 0x02 low, 0x03 high
  - source address: 0x14, 0x15, 0x16, low to high, 22 bits
  - mode: 0x18
  - raster operation: 0x1a
- R3: The destination address sits at 0x10, 0x11 and 0x12, low to high. After any of these writes the stored address is masked to 22 bits when BIG_MEM=1 and to 21 bits when BIG_MEM=0.
- R4: Offset 0x1b is the mode-extension byte. Its bit 2 selects solid fill, bit 1 inverts the transparency sense of colour expansion, and bit 0 selects dword granularity. It is writable only when NEW_GEN=1. When NEW_GEN=0 writes to it are ignored and it reads 0x00.
- R5: Every write to offset 0x40 is latched. If bit 1 of the written value is set, a transfer launches, and busy and a one-cycle start pulse appear on the clock edge that takes the write.
- R6: A write to 0x40 with bit 1 clear stores the byte but launches nothing.
- R7: When NEW_GEN=1, a write to 0x12 while latched bit 7 of 0x40 is set launches a transfer that uses the new destination address. When NEW_GEN=0 such a write launches nothing.
- R8: When the mode byte equals 0x04 (host-fed source), a launch gives no start pulse. Instead it sets host_active, pulses host_clr for one cycle, and copies the source and destination addresses into work_src and work_dst.
- R9: A read of 0x40 returns the latched byte with bit 0 replaced by busy. The done_in signal clears busy, host_active and latched bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data at bus_addr, combinational |
| done_in | input | 1 | Datapath transfer finished |
| start_pulse | output | 1 | One-cycle engine start |
| host_active | output | 1 | Host-fed transfer armed |
| host_clr | output | 1 | One-cycle clear of datapath host counters |
| busy | output | 1 | Transfer in progress |
| dst_addr | output | 22 | Destination address |
| src_addr | output | 22 | Source address |
| work_dst | output | 22 | Destination snapshot at host launch |
| work_src | output | 22 | Source snapshot at host launch |
| dst_pitch | output | 16 | Destination pitch |
| src_pitch | output | 16 | Source pitch |
| mode | output | 8 | Mode byte |
| rop | output | 8 | Raster-operation code |
| mode_ext | output | 8 | Mode-extension byte |

## Verification
Each register output, busy, host_active and the two one-cycle strobes change on the first rising edge after the write or done_in that causes them. That gives one cycle of latency. The read port is combinational and shows the new value as soon as that edge has passed. The bench drives every input on the falling edge and samples one falling edge later, which catches each strobe in its only high cycle. It then checks one cycle further on that the strobe has dropped. A second instance with the older generation and small memory covers the ignored mode-extension write, the 21-bit mask and the absence of auto-launch.

// File: rtl/blt_regbank.sv
module blt_regbank #(
  parameter bit NEW_GEN = 1'b1,
  parameter bit BIG_MEM = 1'b1,
  parameter int ADDR_W = 22,
  parameter int PITCH_W = 16,
  parameter logic [7:0] HOST_MODE = 8'h04
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic                 done_in,
  output logic                 start_pulse,
  output logic                 host_active,
  output logic                 host_clr,
  output logic                 busy,
  output logic [ADDR_W-1:0]    dst_addr,
  output logic [ADDR_W-1:0]    src_addr,
  output logic [ADDR_W-1:0]    work_dst,
  output logic [ADDR_W-1:0]    work_src,
  output logic [PITCH_W-1:0]   dst_pitch,
  output logic [PITCH_W-1:0]   src_pitch,
  output logic [7:0]           mode,
  output logic [7:0]           rop,
  output logic [7:0]           mode_ext
);
  localparam int DST_W = BIG_MEM ? ADDR_W : ADDR_W - 1;
  localparam int TOP_W = ADDR_W - 16;
  localparam logic [ADDR_W-1:0] DST_MASK = {ADDR_W{1'b1}} >> (ADDR_W - DST_W);

  logic [ADDR_W-1:0] dst_q, src_q, dst_raw, dst_next, src_next;
  logic [PITCH_W-1:0] dpitch_q, spitch_q;
  logic [7:0] mode_q, rop_q, mext_q, start_q;
  logic wr_dst, wr_src, launch;

  assign wr_dst = bus_wr && (bus_addr == 8'h10 || bus_addr == 8'h11 || bus_addr == 8'h12);
  assign wr_src = bus_wr && (bus_addr == 8'h14 || bus_addr == 8'h15 || bus_addr == 8'h16);

  always_comb begin
    dst_raw  = dst_q;
    src_next = src_q;
    case (bus_addr)
      8'h10: dst_raw[7:0]         = bus_wdata;
      8'h11: dst_raw[15:8]        = bus_wdata;
      8'h12: dst_raw[ADDR_W-1:16] = bus_wdata[TOP_W-1:0];
      8'h14: src_next[7:0]         = bus_wdata;
      8'h15: src_next[15:8]        = bus_wdata;
      8'h16: src_next[ADDR_W-1:16] = bus_wdata[TOP_W-1:0];
      default: ;
    endcase
    dst_next = dst_raw & DST_MASK;
  end

  assign launch = bus_wr && ((bus_addr == 8'h40 && bus_wdata[1]) ||
                             (NEW_GEN && bus_addr == 8'h12 && start_q[7]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_q <= '0; src_q <= '0; work_dst <= '0; work_src <= '0;
      dpitch_q <= '0; spitch_q <= '0;
      mode_q <= '0; rop_q <= '0; mext_q <= '0; start_q <= '0;
      busy <= 1'b0; host_active <= 1'b0; start_pulse <= 1'b0; host_clr <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      host_clr    <= 1'b0;
      if (done_in) begin
        busy        <= 1'b0;
        host_active <= 1'b0;
        start_q[1]  <= 1'b0;
      end
      if (wr_dst) dst_q <= dst_next;
      if (wr_src) src_q <= src_next;
      if (bus_wr) begin
        case (bus_addr)
          8'h00: dpitch_q[7:0]         <= bus_wdata;
          8'h01: dpitch_q[PITCH_W-1:8] <= bus_wdata[PITCH_W-9:0];
          8'h02: spitch_q[7:0]         <= bus_wdata;
          8'h03: spitch_q[PITCH_W-1:8] <= bus_wdata[PITCH_W-9:0];
          8'h18: mode_q  <= bus_wdata;
          8'h1a: rop_q   <= bus_wdata;
          8'h1b: if (NEW_GEN) mext_q <= bus_wdata;
          8'h40: start_q <= bus_wdata;
          default: ;
        endcase
      end
      if (launch) begin
        busy <= 1'b1;
        if (mode_q == HOST_MODE) begin
          host_active <= 1'b1;
          host_clr    <= 1'b1;
          work_src    <= src_q;
          work_dst    <= dst_next;
        end else begin
          host_active <= 1'b0;
          start_pulse <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      8'h00: bus_rdata = dpitch_q[7:0];
      8'h01: bus_rdata = 8'(dpitch_q[PITCH_W-1:8]);
      8'h02: bus_rdata = spitch_q[7:0];
      8'h03: bus_rdata = 8'(spitch_q[PITCH_W-1:8]);
      8'h10: bus_rdata = dst_q[7:0];
      8'h11: bus_rdata = dst_q[15:8];
      8'h12: bus_rdata = 8'(dst_q[ADDR_W-1:16]);
      8'h14: bus_rdata = src_q[7:0];
      8'h15: bus_rdata = src_q[15:8];
      8'h16: bus_rdata = 8'(src_q[ADDR_W-1:16]);
      8'h18: bus_rdata = mode_q;
      8'h1a: bus_rdata = rop_q;
      8'h1b: bus_rdata = mext_q;
      8'h40: bus_rdata = {start_q[7:1], busy};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign dst_addr  = dst_q;
  assign src_addr  = src_q;
  assign dst_pitch = dpitch_q;
  assign src_pitch = spitch_q;
  assign mode      = mode_q;
  assign rop       = rop_q;
  assign mode_ext  = mext_q;
endmodule

// File: rtl/blt_regbank_chk.sv
module blt_regbank_chk #(
  parameter bit NEW_GEN = 1'b1,
  parameter bit BIG_MEM = 1'b1,
  parameter int ADDR_W = 22,
  parameter logic [7:0] HOST_MODE = 8'h04
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [7:0]        bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              done_in,
  input logic              start_pulse,
  input logic              host_active,
  input logic              host_clr,
  input logic              busy,
  input logic [7:0]        mode,
  input logic [7:0]        mode_ext,
  input logic [ADDR_W-1:0] dst_addr
);
  // R5
  go_write_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h40 && bus_wdata[1] && mode != HOST_MODE) |=> (start_pulse && busy));

  // R6
  plain_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h40 && !bus_wdata[1] && !busy && !done_in) |=> (!start_pulse && !busy));

  // R8
  host_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && host_active));

  // R8
  host_clr_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr |-> (host_active && busy));

  // R9
  done_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_in && !bus_wr) |=> (!busy && !host_active));

  // R3
  dst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !BIG_MEM |-> !dst_addr[ADDR_W-1]);

  // R4
  ext_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !NEW_GEN |-> (mode_ext == 8'h00));
endmodule

bind blt_regbank blt_regbank_chk #(
  .NEW_GEN(NEW_GEN), .BIG_MEM(BIG_MEM), .ADDR_W(ADDR_W), .HOST_MODE(HOST_MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .done_in(done_in), .start_pulse(start_pulse), .host_active(host_active),
  .host_clr(host_clr), .busy(busy), .mode(mode), .mode_ext(mode_ext), .dst_addr(dst_addr)
);

// File: tb/sim_blt_regbank.sv
module sim_blt_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic wr0 = 0, done0 = 0;
  logic [7:0] addr0 = 0, wd0 = 0, rd0;
  logic sp0, ha0, hc0, bz0;
  logic [21:0] da0, sa0, wda0, wsa0;
  logic [15:0] dp0, spt0;
  logic [7:0] md0, rp0, mx0;

  logic wr1 = 0, done1 = 0;
  logic [7:0] addr1 = 0, wd1 = 0, rd1;
  logic sp1, ha1, hc1, bz1;
  logic [21:0] da1, sa1, wda1, wsa1;
  logic [15:0] dp1, spt1;
  logic [7:0] md1, rp1, mx1;

  int n_chk = 0, n_bad = 0;

  blt_regbank u0 (.clk(clk), .rst_n(rst_n), .bus_wr(wr0), .bus_addr(addr0), .bus_wdata(wd0),
    .bus_rdata(rd0), .done_in(done0), .start_pulse(sp0), .host_active(ha0), .host_clr(hc0),
    .busy(bz0), .dst_addr(da0), .src_addr(sa0), .work_dst(wda0), .work_src(wsa0),
    .dst_pitch(dp0), .src_pitch(spt0), .mode(md0), .rop(rp0), .mode_ext(mx0));

  blt_regbank #(.NEW_GEN(1'b0), .BIG_MEM(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .bus_wr(wr1),
    .bus_addr(addr1), .bus_wdata(wd1), .bus_rdata(rd1), .done_in(done1), .start_pulse(sp1),
    .host_active(ha1), .host_clr(hc1), .busy(bz1), .dst_addr(da1), .src_addr(sa1),
    .work_dst(wda1), .work_src(wsa1), .dst_pitch(dp1), .src_pitch(spt1), .mode(md1),
    .rop(rp1), .mode_ext(mx1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w0(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr0 = 1; addr0 = a; wd0 = d;
    @(negedge clk); wr0 = 0;
  endtask

  task automatic w1(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr1 = 1; addr1 = a; wd1 = d;
    @(negedge clk); wr1 = 0;
  endtask

  task automatic r0(input logic [7:0] a, output logic [7:0] v);
    addr0 = a; #1 v = rd0;
  endtask

  task automatic r1(input logic [7:0] a, output logic [7:0] v);
    addr1 = a; #1 v = rd1;
  endtask

  task automatic finish0;
    @(negedge clk); done0 = 1;
    @(negedge clk); done0 = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    foreach (v[i]) ;
    for (int a = 0; a < 8'h42; a++) begin
      r0(8'(a), v);
      if (v !== 8'h00) chk("R1 read after reset", {24'h0, v}, 32'h0);
    end
    chk("R1 busy/host/pulse/clr", {bz0, ha0, sp0, hc0}, 4'b0000);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    w0(8'h00, 8'h40); w0(8'h01, 8'h06); w0(8'h02, 8'h80); w0(8'h03, 8'h02);
    w0(8'h18, 8'h11); w0(8'h1a, 8'hcc);
    chk("R2 dst pitch", dp0, 16'h0640);
    chk("R2 src pitch", spt0, 16'h0280);
    chk("R2 mode/rop", {md0, rp0}, 16'h11cc);
    r0(8'h1a, v); chk("R2 rop readback", v, 8'hcc);
    r0(8'h03, v); chk("R2 src pitch high readback", v, 8'h02);
    w0(8'h18, 8'h00);
  endtask

  task automatic t_dst_mask;
    logic [7:0] v;
    w0(8'h10, 8'h34); w0(8'h11, 8'h12); w0(8'h12, 8'hff);
    chk("R3 dst 22-bit", da0, 22'h3f1234);
    r0(8'h12, v); chk("R3 dst top byte readback", v, 8'h3f);
    w1(8'h12, 8'hff);
    chk("R3 dst 21-bit", da1, 22'h1f0000);
    r1(8'h12, v); chk("R3 small top byte readback", v, 8'h1f);
  endtask

  task automatic t_ext;
    logic [7:0] v;
    w0(8'h1b, 8'h07);
    chk("R4 mode_ext new gen", mx0, 8'h07);
    r0(8'h1b, v); chk("R4 mode_ext readback", v, 8'h07);
    w1(8'h1b, 8'h07);
    r1(8'h1b, v); chk("R4 mode_ext ignored old gen", v, 8'h00);
  endtask

  task automatic t_plain_start;
    logic [7:0] v;
    w0(8'h40, 8'h80);
    chk("R6 no pulse/busy", {sp0, bz0}, 2'b00);
    r0(8'h40, v); chk("R6 byte latched", v, 8'h80);
  endtask

  task automatic t_launch;
    logic [7:0] v;
    w0(8'h40, 8'h02);
    chk("R5 start pulse and busy", {sp0, bz0, ha0}, 3'b110);
    r0(8'h40, v); chk("R9 status busy bit", v, 8'h03);
    @(negedge clk);
    chk("R5 pulse one cycle", {sp0, bz0}, 2'b01);
    finish0;
    chk("R9 busy cleared by done", bz0, 1'b0);
    r0(8'h40, v); chk("R9 go bit cleared", v, 8'h00);
  endtask

  task automatic t_auto;
    logic [7:0] v;
    w0(8'h40, 8'h80);
    w0(8'h10, 8'h78); w0(8'h11, 8'h56);
    chk("R7 low bytes no launch", {sp0, bz0}, 2'b00);
    w0(8'h12, 8'h2a);
    chk("R7 auto launch", {sp0, bz0}, 2'b11);
    chk("R7 new dst used", da0, 22'h2a5678);
    finish0;
    r0(8'h40, v); chk("R9 status after auto", v, 8'h80);
    w1(8'h40, 8'h80); w1(8'h12, 8'h01);
    chk("R7 no auto old gen", {sp1, bz1}, 2'b00);
  endtask

  task automatic t_host;
    w0(8'h40, 8'h00);
    w0(8'h18, 8'h04);
    w0(8'h14, 8'h55); w0(8'h15, 8'haa); w0(8'h16, 8'h05);
    chk("R2 src readback", sa0, 22'h05aa55);
    w0(8'h40, 8'h02);
    chk("R8 armed no pulse", {sp0, ha0, hc0, bz0}, 4'b0111);
    chk("R8 work src", wsa0, 22'h05aa55);
    chk("R8 work dst", wda0, 22'h2a5678);
    @(negedge clk);
    chk("R8 clr one cycle", {hc0, ha0}, 2'b01);
    finish0;
    chk("R9 host dropped by done", {ha0, bz0}, 2'b00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_regs;
        t_dst_mask;
        t_ext;
        t_plain_start;
        t_launch;
        t_auto;
        t_host;
      end
      begin
        repeat (5000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule